// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host side of a link to a multi-channel 10-bit successive-approximation converter that talks over a four-wire synchronous serial port (active-low select, serial clock, host-to-converter data, converter-to-host data) plus an end-of-conversion strobe line. When the system asks for a sample, the sequencer forms an 8-bit command byte. The byte carries a self-framing leading one, the channel number, the polarity and input-type selections and two power-management bits. The sequencer shifts it out MSB first and then reads back the 10-bit code.

Two clocking modes are offered per request. In the externally clocked mode, the serial clock runs without a break for a whole 24-clock frame, and the code is taken on the clocks right after the command. In the self-timed mode, the serial clock stops after the command, and the sequencer waits for the converter's strobe to rise before it clocks out the result. A timer guards this wait. The serial clock is divided down from the system clock by a requested half-period, which is clamped to the legal range for the chosen reference compensation. After reset the sequencer stays busy for the converter's start-up interval before it accepts any request.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While rst_n is low and for 20000 system cycles after its release (STARTUP_US at SYS_HZ), busy is 1, adc_csn is 1, adc_sck is 0 and result_valid is 0. A conv_req in that window starts no frame.
- R2: On adc_mosi the converter sees, at rising adc_sck edges 1 to 8 of a frame, the bits 1, conv_chan[2], conv_chan[1], conv_chan[0], conv_unipolar, conv_single, conv_pd[1], conv_pd[0], in that order. adc_mosi never changes while adc_sck is high or in the cycle adc_sck rises.
- R3: Each adc_sck high or low phase lasts sck_div system cycles, clamped to HALF_MIN..HALF_MAX, which is 50..1000 at the defaults (2 MHz down to 100 kHz; HALF_MIN grows to 250 when INT_COMP=1). The value is latched when the request is taken.
- R4: With conv_self_timed=0 the frame has 24 back-to-back rising edges. B9 down to B0 are taken from adc_miso on rising edges 9 to 18, and the later bits, including the two sub-LSB bits, are dropped.
- R5: With conv_self_timed=1 (honoured only when INT_COMP=0), adc_sck stays low after edge 8 until adc_eoc rises. Then 16 more rising edges follow, and B9..B0 are taken on the first 10 of them.
- R6: If adc_eoc has not risen within 2400 cycles (12 us) of the start of the wait, timeout_err pulses for one cycle, adc_csn goes high with no further clocks, result keeps its old value, no result_valid is given, and busy falls.
- R7: At the end of a frame, result_valid pulses for exactly one cycle, in the same cycle adc_csn returns high, and result holds B9..B0 until the next completion.
- R8: busy is 1 from the cycle after a request is taken until the frame ends. A conv_req seen while busy is ignored.
- R9: When no frame is in progress, adc_csn is 1 and adc_sck is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_req | input | 1 | Request one conversion (taken when idle) |
| conv_chan | input | 3 | Channel number |
| conv_unipolar | input | 1 | Unipolar (1) or bipolar (0) coding |
| conv_single | input | 1 | Single-ended (1) or differential (0) input |
| conv_pd | input | 2 | Power-management bits placed in the command |
| conv_self_timed | input | 1 | 1 selects the strobe-waiting self-timed mode |
| sck_div | input | 16 | Requested serial-clock half period in system cycles |
| busy | output | 1 | Frame or start-up interval in progress |
| result | output | 10 | Last converted code |
| result_valid | output | 1 | One-cycle pulse on a new code |
| timeout_err | output | 1 | One-cycle pulse on a strobe-wait timeout |
| adc_csn | output | 1 | Converter select, active low |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_mosi | output | 1 | Command data to the converter |
| adc_miso | input | 1 | Result data from the converter |
| adc_eoc | input | 1 | End-of-conversion strobe, high when done |

## Verification
A behavioural converter model decodes the command as it arrives, returns a channel-dependent code, and pads the code with two set sub-LSB bits. The set padding shows whether the sequencer samples at the right edges or picks up trailing bits. Externally clocked frames run with an in-range divider, one below the floor and one above the ceiling, and the measured clock period shows whether clamping happens. Self-timed frames run with a converter that answers and with one that never raises its strobe. These two separate the clock-hold behaviour from the timeout exit, and the timeout case also shows that the old result survives. A second request sent in the middle of a frame and a request sent during start-up show whether either one leaks into an extra frame.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_WORD,
    ST_WAIT,
    ST_READ
  } seq_state_t;

  localparam int unsigned CMD_BITS    = 8;
  localparam int unsigned CODE_BITS   = 10;
  localparam int unsigned READ_CLOCKS = 16;
  localparam int unsigned SCK_MIN_HZ  = 100_000;
  localparam int unsigned SCK_MAX_EXT = 2_000_000;
  localparam int unsigned SCK_MAX_INT = 400_000;

  // Shortest legal half period (rounded up) for the compensation choice.
  function automatic int unsigned half_min(int unsigned sys_hz, int int_comp);
    int unsigned fmax;
    fmax = (int_comp != 0) ? SCK_MAX_INT : SCK_MAX_EXT;
    return (sys_hz + 2 * fmax - 1) / (2 * fmax);
  endfunction

  // Longest legal half period, set by the minimum serial clock rate.
  function automatic int unsigned half_max(int unsigned sys_hz);
    return sys_hz / (2 * SCK_MIN_HZ);
  endfunction

  function automatic int unsigned us_to_cycles(int unsigned sys_hz, int unsigned us);
    return (sys_hz / 1_000_000) * us;
  endfunction

  function automatic logic [15:0] clamp_half(logic [15:0] d, int unsigned lo, int unsigned hi);
    if (32'(d) < lo) return 16'(lo);
    if (32'(d) > hi) return 16'(hi);
    return d;
  endfunction

  // Leading one frames the command for the converter.
  function automatic logic [7:0] build_cmd(logic [2:0] chan, logic uni, logic sgl, logic [1:0] pd);
    return {1'b1, chan, uni, sgl, pd};
  endfunction

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] half_len,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && (cnt == half_len - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/adc_seq_eoc_mon.sv
module adc_seq_eoc_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_async,
  output logic eoc_rise
);
  // Strobe idles high at power-up, so all stages reset to one.
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= eoc_async;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign eoc_rise = s2 && !s3;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned SYS_HZ         = 200_000_000,
  parameter int          INT_COMP       = 0,
  parameter int unsigned STARTUP_US     = 100,
  parameter int unsigned EOC_TIMEOUT_US = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        conv_req,
  input  logic [2:0]  conv_chan,
  input  logic        conv_unipolar,
  input  logic        conv_single,
  input  logic [1:0]  conv_pd,
  input  logic        conv_self_timed,
  input  logic [15:0] sck_div,
  output logic        busy,
  output logic [9:0]  result,
  output logic        result_valid,
  output logic        timeout_err,
  output logic        adc_csn,
  output logic        adc_sck,
  output logic        adc_mosi,
  input  logic        adc_miso,
  input  logic        adc_eoc
);
  import adc_seq_pkg::*;

  localparam int unsigned HALF_MIN = half_min(SYS_HZ, INT_COMP);
  localparam int unsigned HALF_MAX = half_max(SYS_HZ);
  localparam int unsigned BOOT_CYC = us_to_cycles(SYS_HZ, STARTUP_US);
  localparam int unsigned TO_CYC   = us_to_cycles(SYS_HZ, EOC_TIMEOUT_US);
  localparam int unsigned TMAX     = (BOOT_CYC > TO_CYC) ? BOOT_CYC : TO_CYC;
  localparam int          TW       = $clog2(TMAX + 1);
  localparam logic [TW-1:0] BOOT_LAST = TW'(BOOT_CYC - 1);
  localparam logic [TW-1:0] TO_LAST   = TW'(TO_CYC - 1);
  localparam logic [4:0] CMD_END  = 5'(CMD_BITS);
  localparam logic [4:0] READ_END = 5'(READ_CLOCKS);
  localparam logic [4:0] CODE_END = 5'(CODE_BITS);

  seq_state_t     state;
  logic [7:0]     cmd_sr;
  logic [9:0]     code_sr;
  logic [4:0]     edge_n;
  logic [15:0]    half_q;
  logic           self_q;
  logic [TW-1:0]  timer;
  logic           sck_q, csn_q, mosi_q, valid_q, err_q;
  logic [9:0]     result_q;

  // Named internal events.
  logic half_tick, sck_rise_ev, sck_fall_ev, eoc_rise;
  logic req_take, boot_done, cmd_done, read_done, sample_ev, wait_expired;
  logic run_clk, use_self;

  assign run_clk      = (state == ST_WORD) || (state == ST_READ);
  assign sck_rise_ev  = half_tick && !sck_q;
  assign sck_fall_ev  = half_tick && sck_q;
  assign req_take     = (state == ST_IDLE) && conv_req;
  assign boot_done    = (state == ST_BOOT) && (timer == BOOT_LAST);
  assign cmd_done     = (state == ST_WORD) && sck_fall_ev && (edge_n == CMD_END);
  assign read_done    = (state == ST_READ) && sck_fall_ev && (edge_n == READ_END);
  assign sample_ev    = (state == ST_READ) && sck_rise_ev && (edge_n < CODE_END);
  assign wait_expired = (state == ST_WAIT) && (timer == TO_LAST);
  assign use_self     = conv_self_timed && (INT_COMP == 0);

  adc_seq_tick #(.W(16)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_clk),
    .half_len (half_q),
    .tick     (half_tick)
  );

  adc_seq_eoc_mon u_eoc (
    .clk       (clk),
    .rst_n     (rst_n),
    .eoc_async (adc_eoc),
    .eoc_rise  (eoc_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_BOOT;
      cmd_sr   <= '0;
      code_sr  <= '0;
      edge_n   <= '0;
      half_q   <= 16'(HALF_MIN);
      self_q   <= 1'b0;
      timer    <= '0;
      sck_q    <= 1'b0;
      csn_q    <= 1'b1;
      mosi_q   <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      case (state)
        ST_BOOT: begin
          timer <= timer + TW'(1);
          if (boot_done) begin
            timer <= '0;
            state <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (req_take) begin
            logic [7:0] w;
            w       = build_cmd(conv_chan, conv_unipolar, conv_single, conv_pd);
            mosi_q  <= w[7];
            cmd_sr  <= {w[6:0], 1'b0};
            half_q  <= clamp_half(sck_div, HALF_MIN, HALF_MAX);
            self_q  <= use_self;
            edge_n  <= '0;
            csn_q   <= 1'b0;
            state   <= ST_WORD;
          end
        end
        ST_WORD: begin
          if (sck_rise_ev) begin
            sck_q  <= 1'b1;
            edge_n <= edge_n + 5'd1;
          end else if (sck_fall_ev) begin
            sck_q <= 1'b0;
            if (cmd_done) begin
              mosi_q <= 1'b0;
              edge_n <= '0;
              timer  <= '0;
              state  <= self_q ? ST_WAIT : ST_READ;
            end else begin
              mosi_q <= cmd_sr[7];
              cmd_sr <= {cmd_sr[6:0], 1'b0};
            end
          end
        end
        ST_WAIT: begin
          timer <= timer + TW'(1);
          if (eoc_rise) begin
            timer <= '0;
            state <= ST_READ;
          end else if (wait_expired) begin
            timer <= '0;
            csn_q <= 1'b1;
            err_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_READ: begin
          if (sck_rise_ev) begin
            sck_q  <= 1'b1;
            edge_n <= edge_n + 5'd1;
            if (sample_ev) code_sr <= {code_sr[8:0], adc_miso};
          end else if (sck_fall_ev) begin
            sck_q <= 1'b0;
            if (read_done) begin
              csn_q    <= 1'b1;
              result_q <= code_sr;
              valid_q  <= 1'b1;
              state    <= ST_IDLE;
            end
          end
        end
        default: state <= ST_BOOT;
      endcase
    end
  end

  assign busy         = (state != ST_IDLE);
  assign result       = result_q;
  assign result_valid = valid_q;
  assign timeout_err  = err_q;
  assign adc_csn      = csn_q;
  assign adc_sck      = sck_q;
  assign adc_mosi     = mosi_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int unsigned SYS_HZ     = 200_000_000,
  parameter int          INT_COMP   = 0,
  parameter int unsigned STARTUP_US = 100
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic result_valid,
  input logic timeout_err,
  input logic adc_csn,
  input logic adc_sck,
  input logic adc_mosi
);
  import adc_seq_pkg::*;

  localparam int unsigned HALF_MIN = half_min(SYS_HZ, INT_COMP);
  localparam int unsigned HALF_MAX = half_max(SYS_HZ);
  localparam int unsigned BOOT_CYC = us_to_cycles(SYS_HZ, STARTUP_US);

  logic [31:0] boot_cnt;
  logic [15:0] span;
  logic        sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_cnt <= '0;
      span     <= '0;
      sck_d    <= 1'b0;
    end else begin
      if (boot_cnt < BOOT_CYC) boot_cnt <= boot_cnt + 32'd1;
      sck_d <= adc_sck;
      if (adc_sck != sck_d)     span <= 16'd1;
      else if (span != 16'hFFFF) span <= span + 16'd1;
    end
  end

  a_r1_quiet_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_cnt < BOOT_CYC) |-> (adc_csn && busy));

  a_r2_mosi_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sck && $past(adc_sck)) |-> $stable(adc_mosi));

  a_r2_mosi_held_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sck) |-> $stable(adc_mosi));

  a_r3_min_span: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_csn && !$stable(adc_sck)) |-> (32'(span) >= HALF_MIN));

  a_r3_high_span: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sck) |-> (32'(span) <= HALF_MAX));

  a_r6_err_closes: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (adc_csn && !result_valid && !busy));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  a_r7_cs_up: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> adc_csn);

  a_r8_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_csn |-> busy);

  a_r9_sck_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
    adc_csn |-> !adc_sck);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .SYS_HZ     (SYS_HZ),
  .INT_COMP   (INT_COMP),
  .STARTUP_US (STARTUP_US)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .result_valid (result_valid),
  .timeout_err  (timeout_err),
  .adc_csn      (adc_csn),
  .adc_sck      (adc_sck),
  .adc_mosi     (adc_mosi)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int BOOT    = 20000;
  localparam int CONV_NS = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_req = 1'b0;
  logic [2:0]  conv_chan = '0;
  logic        conv_unipolar = 1'b0;
  logic        conv_single = 1'b0;
  logic [1:0]  conv_pd = '0;
  logic        conv_self_timed = 1'b0;
  logic [15:0] sck_div = 16'd60;
  logic        busy, result_valid, timeout_err, adc_csn, adc_sck, adc_mosi;
  logic [9:0]  result;
  logic        adc_miso = 1'b0;
  logic        adc_eoc = 1'b1;

  always #2.5 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_unipolar(conv_unipolar), .conv_single(conv_single), .conv_pd(conv_pd),
    .conv_self_timed(conv_self_timed), .sck_div(sck_div), .busy(busy),
    .result(result), .result_valid(result_valid), .timeout_err(timeout_err),
    .adc_csn(adc_csn), .adc_sck(adc_sck), .adc_mosi(adc_mosi),
    .adc_miso(adc_miso), .adc_eoc(adc_eoc)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] code_for(logic [2:0] c);
    return 10'(c) * 10'd97 + 10'd13;
  endfunction

  // Scoreboard.
  typedef struct { logic [9:0] code; bit err; } exp_t;
  exp_t sbq[$];

  always @(negedge clk) begin
    if (rst_n && (result_valid || timeout_err)) begin
      if (sbq.size() == 0) begin
        check(0, "R7", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (e.err) check(timeout_err && !result_valid, "R6", "timeout flag", int'(timeout_err), 1);
        else begin
          check(result_valid && !timeout_err, "R7", "valid flag", int'(result_valid), 1);
          check(result == e.code, "R4", "result code", int'(result), int'(e.code));
        end
      end
    end
  end

  // Behavioural converter model.
  int         dev_rise = 0, last_rises = 0, frames = 0;
  logic [7:0] dev_word = '0, cap_word = '0;
  logic [23:0] dev_out = '0;
  logic [9:0] dev_code = '0;
  bit         dev_self = 0, dev_hang = 0, eoc_bad = 0;
  realtime    t_first = 0, per = 0;

  always @(negedge adc_csn) begin
    dev_rise = 0;
    frames++;
  end
  always @(posedge adc_csn) last_rises = dev_rise;

  always @(posedge adc_sck) if (!adc_csn) begin
    dev_rise++;
    if (!adc_eoc) eoc_bad = 1;
    dev_word = {dev_word[6:0], adc_mosi};
    if (dev_rise == 1) t_first = $realtime;
    if (dev_rise == 2) per = $realtime - t_first;
    if (dev_rise == 8) begin
      cap_word = dev_word;
      dev_code = code_for(dev_word[6:4]);
      if (dev_self) begin
        adc_eoc = 1'b0;
        if (!dev_hang) fork
          begin
            #(CONV_NS);
            dev_out  = {dev_code, 2'b11, 12'h000};
            adc_miso = dev_out[23];
            adc_eoc  = 1'b1;
          end
        join_none
      end
    end
  end

  always @(negedge adc_sck) if (!adc_csn) begin
    if (!dev_self && dev_rise == 8) begin
      dev_out  = {dev_code, 2'b11, 12'h000};
      adc_miso = dev_out[23];
    end else if (dev_rise > 8) begin
      dev_out  = {dev_out[22:0], 1'b0};
      adc_miso = dev_out[23];
    end
  end

  logic [9:0] last_code = '0;

  task automatic run_conv(input logic [2:0] ch, input bit uni, input bit sgl,
                          input logic [1:0] pd, input bit self_t, input logic [15:0] div,
                          input bit hang, input bit extra_req, input int exp_half);
    int f0;
    exp_t e;
    while (busy) @(negedge clk);
    dev_self = self_t;
    dev_hang = hang;
    e.code = code_for(ch);
    e.err  = hang;
    sbq.push_back(e);
    f0 = frames;
    conv_chan = ch; conv_unipolar = uni; conv_single = sgl; conv_pd = pd;
    conv_self_timed = self_t; sck_div = div; conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    check(busy == 1'b1, "R8", "busy after take", int'(busy), 1);
    if (extra_req) begin
      repeat (100) @(negedge clk);
      conv_chan = ch ^ 3'd7;
      conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
    end
    while (busy) @(negedge clk);
    check(cap_word == {1'b1, ch, uni, sgl, pd}, "R2", "command byte", int'(cap_word),
          int'({1'b1, ch, uni, sgl, pd}));
    check(int'(per) == 10 * exp_half, "R3", "sck period ns", int'(per), 10 * exp_half);
    check(adc_csn && !adc_sck, "R9", "idle lines csn/sck", int'({adc_csn, adc_sck}), 2);
    if (hang) begin
      check(last_rises == 8, "R6", "edges before timeout", last_rises, 8);
      check(result == last_code, "R6", "result kept", int'(result), int'(last_code));
      adc_eoc = 1'b1;
      dev_hang = 0;
    end else begin
      check(last_rises == 24, self_t ? "R5" : "R4", "edges per frame", last_rises, 24);
      last_code = code_for(ch);
    end
    if (self_t && !hang) check(!eoc_bad, "R5", "clock while strobe low", int'(eoc_bad), 0);
    repeat (3) @(negedge clk);
    check(frames == f0 + 1, "R8", "frames started", frames - f0, 1);
    eoc_bad = 0;
  endtask

  initial begin
    int boot_cycles;
    repeat (5) @(negedge clk);
    check(adc_csn && !adc_sck && busy && !result_valid, "R1", "reset state",
          int'({adc_csn, adc_sck, busy, result_valid}), 10);
    rst_n = 1'b1;
    boot_cycles = 0;
    while (busy) begin
      @(negedge clk);
      boot_cycles++;
      if (boot_cycles == 50) conv_req = 1'b1;
      if (boot_cycles == 51) conv_req = 1'b0;
      if (boot_cycles == 300)
        check(adc_csn && frames == 0, "R1", "request during start-up", frames, 0);
    end
    check(boot_cycles >= BOOT - 1 && boot_cycles <= BOOT + 1, "R1", "start-up length",
          boot_cycles, BOOT);
    repeat (5) @(negedge clk);
    check(frames == 0, "R1", "no frame from early request", frames, 0);

    run_conv(3'd5, 1, 1, 2'b11, 0, 16'd60,   0, 0, 60);    // R4 normal
    run_conv(3'd2, 0, 0, 2'b01, 0, 16'd10,   0, 0, 50);    // R3 floor
    run_conv(3'd7, 1, 0, 2'b10, 1, 16'd60,   0, 0, 60);    // R5 self-timed
    run_conv(3'd0, 0, 1, 2'b10, 1, 16'd60,   1, 0, 60);    // R6 timeout
    run_conv(3'd3, 1, 1, 2'b11, 0, 16'd60,   0, 1, 60);    // R8 extra request
    run_conv(3'd6, 0, 1, 2'b10, 1, 16'd80,   0, 0, 80);    // R5 after timeout
    run_conv(3'd1, 1, 0, 2'b11, 0, 16'd5000, 0, 0, 1000);  // R3 ceiling

    check(sbq.size() == 0, "R7", "scoreboard drained", sbq.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule